// File: doc/BRIEF.md
# Programmable-Priority Interrupt Arbiter

This block gathers 28 interrupt sources and drives one interrupt request, at a software-chosen level, to a processor core. Each source has a pending flag, an enable, and an in-service flag. A source is eligible when it is pending, enabled and not in service. When the core acknowledges the request, the block returns the 5-bit vector of the eligible source that wins arbitration and marks that source in service.

Arbitration follows a mostly fixed descending ranking. Vector codes 0 to 3 belong to four serial channels. Codes 4 to 27 are the fixed sources, in descending priority: code 4 is parallel port line 0 (always rank 0) and code 27 is parallel port line 11 (the lowest). One of the fixed sources reports DMA bus errors. The serial channels have no fixed ranks. Four generic slots (a, b, c, d) stand in for them, and a mapping input assigns a channel to each slot. Rewriting the mapping at run time gives rotating priority among the channels. A static placement input puts the four slots either together directly below rank 0 or spread through the ranking. An override input names one source that beats the whole ranking whenever it is eligible.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A source's pending bit is set in the clock after its event input is high. It then stays set until a write-one on its pending-clear bit. If event and clear fall in the same clock, the bit remains set.
- R2: `irq_lvl` equals `lvl_cfg` whenever at least one source is eligible (pending, enabled, not in service), and is zero otherwise. It follows the registered state in the same cycle.
- R3: If `iack` is high at a clock edge, then in the following cycle `ack_vld` is high for exactly one cycle and `ack_vec` holds the winning vector code. When no source was eligible, `ack_vec` is 31.
- R4: An acknowledge sets the winner's in-service bit, and that source stops taking part until a write-one on its in-service-clear bit. If a set and a clear fall in the same clock, the set wins.
- R5: Among the fixed sources, the lower vector code wins: code 4 (port line 0) is highest and code 27 (port line 11) is lowest.
- R6: With `cfg_group`=1 the ranking is code 4, then slots a, b, c, d, then codes 5 to 27.
- R7: With `cfg_group`=0 slots a, b, c, d sit at ranks 1, 8, 15 and 22, and codes 5 to 27 fill the other ranks in order. `cfg_group` must not change while any pending bit is set.
- R8: Slot k (a=0 to d=3) holds the channel numbered by `slot_map[2k+1:2k]`. A new mapping applies to the very next acknowledge.
- R9: When the source coded in `hp_sel` is eligible, it wins over every rank. Setting `hp_sel`=4 leaves the ranking unchanged. Values of 28 and above disable the override.
- R10: A channel that no slot names never wins. Reset clears all pending and in-service bits, `ack_vld` and `irq_lvl`.
- R11: A source whose enable bit is low does not take part in arbitration, but its pending bit still sets and holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | 28 | Per-source event, sets pending |
| src_en | input | 28 | Per-source enable (1 = takes part) |
| pend_clr | input | 28 | Write-one clear of pending bits |
| isr_clr | input | 28 | Write-one clear of in-service bits |
| cfg_group | input | 1 | Slot placement: 1 grouped, 0 spread |
| slot_map | input | 8 | Channel number per slot, 2 bits per slot, slot a in bits 1:0 |
| hp_sel | input | 5 | Vector code of the override source |
| lvl_cfg | input | 3 | Request level presented to the core |
| iack | input | 1 | Interrupt acknowledge strobe |
| irq_lvl | output | 3 | Active request level, 0 when idle |
| ack_vld | output | 1 | Vector valid, one cycle after acknowledge |
| ack_vec | output | 5 | Winning vector code, 31 when spurious |
| pend_q | output | 28 | Pending bits |
| isr_q | output | 28 | In-service bits |

## Verification
Pending and in-service bits change at the edge that samples their event, clear or acknowledge. `ack_vld` and `ack_vec` appear one cycle after the edge that sampled `iack`. `irq_lvl` follows the registered state with no extra delay. The bench drives each input on a falling edge. At the next rising edge its reference model steps, using those same inputs. At the falling edge that follows, it compares every output against the model, so each check falls in the cycle in which its result is due. Directed scenarios clear all state and then apply configuration in an idle cycle before any events. They raise `iack` one cycle later and check `ack_vec` against hand-derived codes.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   typedef enum logic {
      PLACE_SPREAD = 1'b0,
      PLACE_GROUP  = 1'b1
   } place_e;

   // number of generic slots that sit at a rank strictly above rank r
   function automatic int slots_above(input int r, input int stride, input int nch);
      int n;
      if (r <= 1) return 0;
      n = (r - 2) / stride + 1;
      return (n > nch) ? nch : n;
   endfunction

   // slot k occupies rank 1 + k*stride
   function automatic bit rank_is_slot(input int r, input int stride, input int nch);
      return (r >= 1) && (((r - 1) % stride) == 0) && (((r - 1) / stride) < nch);
   endfunction

   function automatic int rank_slot(input int r, input int stride);
      return (r - 1) / stride;
   endfunction

   function automatic int rank_fixed(input int r, input int stride, input int nch);
      return r - slots_above(r, stride, nch);
   endfunction

endpackage

// File: rtl/icu_pend_bank.sv
module icu_pend_bank #(
   parameter int NSRC = 28
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_evt,
   input  logic [NSRC-1:0] pend_clr,
   input  logic [NSRC-1:0] isr_clr,
   input  logic [NSRC-1:0] ack_set,
   output logic [NSRC-1:0] pend_q,
   output logic [NSRC-1:0] isr_q
);

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst) begin
            pend_q[i] <= 1'b0;
            isr_q[i]  <= 1'b0;
         end else begin
            // set has precedence over a simultaneous write-one clear
            if (src_evt[i])       pend_q[i] <= 1'b1;
            else if (pend_clr[i]) pend_q[i] <= 1'b0;
            if (ack_set[i])       isr_q[i]  <= 1'b1;
            else if (isr_clr[i])  isr_q[i]  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/icu_rank_table.sv
module icu_rank_table #(
   parameter int NCHAN  = 4,
   parameter int NSRC   = 28,
   parameter int VW     = 5,
   parameter int CW     = 2,
   parameter int STRIDE = 1
) (
   input  logic [NSRC-1:0]          elig,
   input  logic [NCHAN*CW-1:0]      slot_map,
   output logic [NSRC-1:0]          rank_act,
   output logic [NSRC-1:0][VW-1:0]  rank_code
);

   for (genvar r = 0; r < NSRC; r++) begin : g_rank
      if (prio_irq_pkg::rank_is_slot(r, STRIDE, NCHAN)) begin : g_slot
         localparam int K = prio_irq_pkg::rank_slot(r, STRIDE);
         logic [CW-1:0] ch;
         assign ch           = slot_map[K*CW +: CW];
         assign rank_act[r]  = elig[ch];
         assign rank_code[r] = VW'(ch);
      end else begin : g_fix
         localparam int F = prio_irq_pkg::rank_fixed(r, STRIDE, NCHAN);
         assign rank_act[r]  = elig[NCHAN + F];
         assign rank_code[r] = VW'(NCHAN + F);
      end
   end

endmodule

// File: rtl/icu_pick.sv
module icu_pick #(
   parameter int NSRC = 28,
   parameter int VW   = 5
) (
   input  logic [NSRC-1:0]          rank_act,
   input  logic [NSRC-1:0][VW-1:0]  rank_code,
   input  logic [NSRC-1:0]          elig,
   input  logic [VW-1:0]            hp_sel,
   output logic                     win_vld,
   output logic [VW-1:0]            win_code
);

   logic hp_hit;

   always_comb begin
      hp_hit = 1'b0;
      if (32'(hp_sel) < NSRC) hp_hit = elig[hp_sel];
   end

   always_comb begin
      win_vld  = 1'b0;
      win_code = '0;
      for (int r = NSRC - 1; r >= 0; r--) begin
         if (rank_act[r]) begin
            win_vld  = 1'b1;
            win_code = rank_code[r];
         end
      end
      if (hp_hit) begin
         win_vld  = 1'b1;
         win_code = hp_sel;
      end
   end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
   parameter int NCHAN         = 4,
   parameter int NFIX          = 24,
   parameter int SPREAD_STRIDE = 7,
   parameter int LW            = 3,
   localparam int NSRC = NCHAN + NFIX,
   localparam int VW   = $clog2(NSRC + 1),
   localparam int CW   = $clog2(NCHAN)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NSRC-1:0]      src_evt,
   input  logic [NSRC-1:0]      src_en,
   input  logic [NSRC-1:0]      pend_clr,
   input  logic [NSRC-1:0]      isr_clr,
   input  logic                 cfg_group,
   input  logic [NCHAN*CW-1:0]  slot_map,
   input  logic [VW-1:0]        hp_sel,
   input  logic [LW-1:0]        lvl_cfg,
   input  logic                 iack,
   output logic [LW-1:0]        irq_lvl,
   output logic                 ack_vld,
   output logic [VW-1:0]        ack_vec,
   output logic [NSRC-1:0]      pend_q,
   output logic [NSRC-1:0]      isr_q
);

   import prio_irq_pkg::*;

   localparam logic [VW-1:0] SPUR_CODE = {VW{1'b1}};
   localparam int NVAR = 2;

   if (NCHAN < 2 || (1 << CW) != NCHAN) begin : g_bad_nchan
      $error("NCHAN must be a power of two of at least 2");
   end
   if (NFIX < 1) begin : g_bad_nfix
      $error("NFIX must be at least 1");
   end
   if (SPREAD_STRIDE < 1 || 1 + (NCHAN - 1) * SPREAD_STRIDE >= NSRC) begin : g_bad_stride
      $error("spread slots do not fit in the ranking");
   end

   logic [NSRC-1:0]                    elig;
   logic [NSRC-1:0]                    ack_set;
   logic [NVAR-1:0][NSRC-1:0]          var_act;
   logic [NVAR-1:0][NSRC-1:0][VW-1:0]  var_code;
   logic [NSRC-1:0]                    rank_act;
   logic [NSRC-1:0][VW-1:0]            rank_code;
   logic                               win_vld;
   logic [VW-1:0]                      win_code;
   place_e                             place;

   assign elig  = pend_q & src_en & ~isr_q;
   assign place = place_e'(cfg_group);

   icu_pend_bank #(.NSRC(NSRC)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .src_evt  (src_evt),
      .pend_clr (pend_clr),
      .isr_clr  (isr_clr),
      .ack_set  (ack_set),
      .pend_q   (pend_q),
      .isr_q    (isr_q)
   );

   // one ranking per placement variant: index 0 spread, index 1 grouped
   for (genvar v = 0; v < NVAR; v++) begin : g_var
      localparam int STR = (v == int'(PLACE_GROUP)) ? 1 : SPREAD_STRIDE;
      icu_rank_table #(
         .NCHAN (NCHAN),
         .NSRC  (NSRC),
         .VW    (VW),
         .CW    (CW),
         .STRIDE(STR)
      ) u_tab (
         .elig      (elig),
         .slot_map  (slot_map),
         .rank_act  (var_act[v]),
         .rank_code (var_code[v])
      );
   end

   always_comb begin
      rank_act  = var_act[int'(place)];
      rank_code = var_code[int'(place)];
   end

   icu_pick #(.NSRC(NSRC), .VW(VW)) u_pick (
      .rank_act  (rank_act),
      .rank_code (rank_code),
      .elig      (elig),
      .hp_sel    (hp_sel),
      .win_vld   (win_vld),
      .win_code  (win_code)
   );

   always_comb begin
      ack_set = '0;
      if (iack && win_vld) ack_set = NSRC'(1) << win_code;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_vld <= 1'b0;
         ack_vec <= '0;
      end else begin
         ack_vld <= iack;
         if (iack) ack_vec <= win_vld ? win_code : SPUR_CODE;
      end
   end

   assign irq_lvl = (|elig) ? lvl_cfg : '0;

endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
   parameter int NSRC = 28,
   parameter int VW   = 5,
   parameter int LW   = 3
) (
   input logic            clk,
   input logic            rst,
   input logic [NSRC-1:0] src_evt,
   input logic [NSRC-1:0] src_en,
   input logic [NSRC-1:0] pend_clr,
   input logic            cfg_group,
   input logic [VW-1:0]   hp_sel,
   input logic [LW-1:0]   lvl_cfg,
   input logic            iack,
   input logic [LW-1:0]   irq_lvl,
   input logic            ack_vld,
   input logic [VW-1:0]   ack_vec,
   input logic [NSRC-1:0] pend_q,
   input logic [NSRC-1:0] isr_q
);

   localparam logic [VW-1:0] SPUR = {VW{1'b1}};

   logic [NSRC-1:0] elig;
   logic [NSRC-1:0] elig_d;
   logic            hp_hit;

   assign elig = pend_q & src_en & ~isr_q;

   always_comb begin
      hp_hit = 1'b0;
      if (32'(hp_sel) < NSRC) hp_hit = elig[hp_sel];
   end

   always_ff @(posedge clk) begin
      if (rst) elig_d <= '0;
      else     elig_d <= elig;
   end

   p_evt_sets_r1: assert property (@(posedge clk) disable iff (rst)
      (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

   p_pend_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (|(pend_q & ~pend_clr)) |=> ((pend_q & $past(pend_q & ~pend_clr)) == $past(pend_q & ~pend_clr)));

   p_req_level_r2: assert property (@(posedge clk) disable iff (rst)
      (irq_lvl != '0) |-> ((irq_lvl == lvl_cfg) && (|(pend_q & src_en & ~isr_q))));

   p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      iack |=> ack_vld);

   p_no_ack_r3: assert property (@(posedge clk) disable iff (rst)
      !iack |=> !ack_vld);

   p_spurious_r3: assert property (@(posedge clk) disable iff (rst)
      (iack && !(|elig)) |=> (ack_vec == SPUR));

   p_isr_set_r4: assert property (@(posedge clk) disable iff (rst)
      (iack && (|elig)) |=> ((ack_vec != SPUR) && isr_q[ack_vec]));

   p_group_static_r7: assert property (@(posedge clk) disable iff (rst)
      (|pend_q) |-> $stable(cfg_group));

   p_override_r9: assert property (@(posedge clk) disable iff (rst)
      (iack && hp_hit) |=> (ack_vec == $past(hp_sel)));

   p_win_eligible_r11: assert property (@(posedge clk) disable iff (rst)
      (ack_vld && ack_vec != SPUR) |-> elig_d[ack_vec]);

endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(.NSRC(NSRC), .VW(VW), .LW(LW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .src_evt   (src_evt),
   .src_en    (src_en),
   .pend_clr  (pend_clr),
   .cfg_group (cfg_group),
   .hp_sel    (hp_sel),
   .lvl_cfg   (lvl_cfg),
   .iack      (iack),
   .irq_lvl   (irq_lvl),
   .ack_vld   (ack_vld),
   .ack_vec   (ack_vec),
   .pend_q    (pend_q),
   .isr_q     (isr_q)
);

// File: tb/prio_irq_arbiter_test.sv
`timescale 1ns/1ps
module prio_irq_arbiter_test;

   localparam int NS = 28;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NS-1:0] src_evt  = '0;
   logic [NS-1:0] src_en   = '1;
   logic [NS-1:0] pend_clr = '0;
   logic [NS-1:0] isr_clr  = '0;
   logic          cfg_group = 1'b1;
   logic [7:0]    slot_map = 8'hE4;
   logic [4:0]    hp_sel = 5'd4;
   logic [2:0]    lvl_cfg = 3'd5;
   logic          iack = 1'b0;
   logic [2:0]    irq_lvl;
   logic          ack_vld;
   logic [4:0]    ack_vec;
   logic [NS-1:0] pend_q;
   logic [NS-1:0] isr_q;

   int checks = 0;
   int errors = 0;

   // reference state
   bit [NS-1:0] m_pend = '0;
   bit [NS-1:0] m_isr  = '0;
   bit          m_vld  = 1'b0;
   int          m_vec  = 0;

   always #2.5 clk = ~clk;

   prio_irq_arbiter uut (
      .clk(clk), .rst(rst), .src_evt(src_evt), .src_en(src_en),
      .pend_clr(pend_clr), .isr_clr(isr_clr), .cfg_group(cfg_group),
      .slot_map(slot_map), .hp_sel(hp_sel), .lvl_cfg(lvl_cfg), .iack(iack),
      .irq_lvl(irq_lvl), .ack_vld(ack_vld), .ack_vec(ack_vec),
      .pend_q(pend_q), .isr_q(isr_q)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ranking written as an explicit rank list, override handled first
   function automatic int ref_win();
      int order[$];
      int f;
      bit [NS-1:0] el;
      el = m_pend & src_en & ~m_isr;
      f = 0;
      for (int r = 0; r < NS; r++) begin
         bit is_slot;
         int k;
         if (cfg_group) begin
            is_slot = (r >= 1 && r <= 4); k = r - 1;
         end else begin
            is_slot = (r == 1 || r == 8 || r == 15 || r == 22); k = (r - 1) / 7;
         end
         if (is_slot) order.push_back(int'(slot_map[2*k +: 2]));
         else begin order.push_back(4 + f); f++; end
      end
      if (hp_sel < NS && el[hp_sel]) return int'(hp_sel);
      foreach (order[i]) if (el[order[i]]) return order[i];
      return -1;
   endfunction

   task automatic step();
      int w;
      @(posedge clk);
      w = ref_win();
      if (rst) begin
         m_pend = '0; m_isr = '0; m_vld = 1'b0; m_vec = 0;
      end else begin
         m_vld = iack;
         if (iack) m_vec = (w < 0) ? 31 : w;
         for (int i = 0; i < NS; i++) begin
            if (src_evt[i]) m_pend[i] = 1'b1;
            else if (pend_clr[i]) m_pend[i] = 1'b0;
            if (iack && w == i) m_isr[i] = 1'b1;
            else if (isr_clr[i]) m_isr[i] = 1'b0;
         end
      end
      @(negedge clk);
      check("R1 pend_q", int'(pend_q), int'(m_pend));
      check("R4 isr_q", int'(isr_q), int'(m_isr));
      check("R2 irq_lvl", int'(irq_lvl),
            (|(m_pend & src_en & ~m_isr)) ? int'(lvl_cfg) : 0);
      check("R3 ack_vld", int'(ack_vld), int'(m_vld));
      if (m_vld) check("R3 ack_vec", int'(ack_vec), m_vec);
      src_evt = '0; pend_clr = '0; isr_clr = '0; iack = 1'b0;
   endtask

   // clear all, configure in an idle cycle, raise events, acknowledge
   task automatic scen(input string tag, input bit grp, input logic [7:0] map,
                       input logic [4:0] hp, input logic [NS-1:0] en,
                       input logic [NS-1:0] evts, input int exp);
      pend_clr = '1; isr_clr = '1; step();
      cfg_group = grp; slot_map = map; hp_sel = hp; src_en = en; step();
      src_evt = evts; step();
      iack = 1'b1; step();
      check(tag, int'(ack_vec), exp);
   endtask

   initial begin
      repeat (3) step();
      rst = 1'b0;
      // R10 reset state
      check("R10 reset pend", int'(pend_q), 0);
      check("R10 reset isr", int'(isr_q), 0);
      check("R10 reset irq", int'(irq_lvl), 0);
      check("R10 reset ack_vld", int'(ack_vld), 0);

      scen("R5 fixed order", 1, 8'hE4, 5'd4, '1, (NS'(1) << 27) | (NS'(1) << 5), 5);
      scen("R6 group slot d over code 5", 1, 8'hE4, 5'd4, '1, (NS'(1) << 3) | (NS'(1) << 5), 3);
      scen("R6 group code 4 over slot a", 1, 8'hE4, 5'd4, '1, (NS'(1) << 4) | (NS'(1) << 0), 4);
      scen("R7 spread code 10 over slot b", 0, 8'hE4, 5'd4, '1, (NS'(1) << 1) | (NS'(1) << 10), 10);
      scen("R7 spread slot a over code 5", 0, 8'hE4, 5'd4, '1, (NS'(1) << 0) | (NS'(1) << 5), 0);
      scen("R8 remap ch2 to slot a", 1, 8'h1E, 5'd4, '1, (NS'(1) << 0) | (NS'(1) << 2), 2);
      // R8 remap takes effect on the next acknowledge: ch0 into slot a now
      slot_map = 8'hE4; iack = 1'b1; step();
      check("R8 dynamic remap", int'(ack_vec), 0);
      scen("R10 unmapped channel", 1, 8'h00, 5'd4, '1, (NS'(1) << 3) | (NS'(1) << 27), 27);
      scen("R9 override lowest", 1, 8'hE4, 5'd27, '1, (NS'(1) << 27) | (NS'(1) << 4), 27);
      scen("R9 hp 4 no change", 1, 8'hE4, 5'd4, '1, (NS'(1) << 5) | (NS'(1) << 0), 0);
      scen("R11 masked loses", 1, 8'hE4, 5'd4, ~(NS'(1) << 4), (NS'(1) << 4) | (NS'(1) << 27), 27);
      check("R11 masked still pending", int'(pend_q[4]), 1);
      scen("R3 spurious", 1, 8'hE4, 5'd4, '1, '0, 31);

      // R4 in-service excludes, next ack goes to the next winner
      scen("R4 first winner", 1, 8'hE4, 5'd4, '1, (NS'(1) << 6) | (NS'(1) << 9), 6);
      check("R4 isr bit set", int'(isr_q[6]), 1);
      iack = 1'b1; step();
      check("R4 next winner", int'(ack_vec), 9);
      // R1 event beats clear in the same cycle
      src_evt = NS'(1) << 12; pend_clr = NS'(1) << 12; step();
      check("R1 set beats clear", int'(pend_q[12]), 1);
      // R2 level zero gives no request
      lvl_cfg = 3'd0; step();
      check("R2 level zero", int'(irq_lvl), 0);
      lvl_cfg = 3'd5;

      // randomized phases; placement changes only with nothing pending
      for (int blk = 0; blk < 60; blk++) begin
         pend_clr = '1; isr_clr = '1; step();
         cfg_group = $urandom_range(1, 0) == 1;
         slot_map = 8'($urandom);
         hp_sel = 5'($urandom);
         src_en = NS'($urandom) | NS'($urandom);
         lvl_cfg = 3'($urandom);
         step();
         for (int c = 0; c < 40; c++) begin
            src_evt = NS'($urandom) & NS'($urandom) & NS'($urandom);
            if ($urandom_range(3, 0) == 0) iack = 1'b1;
            if ($urandom_range(7, 0) == 0) pend_clr = NS'($urandom);
            if ($urandom_range(5, 0) == 0) isr_clr = NS'($urandom);
            if ($urandom_range(9, 0) == 0) slot_map = 8'($urandom);
            if ($urandom_range(9, 0) == 0) hp_sel = 5'($urandom);
            step();
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule